// File: doc/BRIEF.md
# Prioritized Event Acceptance and Masking Unit

This unit sits beside a processor core and decides, in every cycle, which pending event the core takes. Ten request lines come in: a debug request, four critical events (unrecoverable exception, translation multiple-hit, bus error and non-maskable interrupt), an ordinary exception line, and one line per interrupt level. Each request is held by its source until it is accepted. The unit does not latch or remember requests.

The unit keeps the mask and mode fields of the status register. A request is eligible only when its mask allows it. The critical events are always eligible. The highest-priority eligible request is accepted in the same cycle. On the next clock edge the unit raises the masks of every source at the same or a lower priority and moves the mode field to the accepted event's level. A simple write port lets the core load the fields, for example when it returns from a handler.

The accepted event is reported as a small identifier, so a downstream table can give each source its own handler address.

Top module: `evtsel_unit`

## Requirements
- R1: After reset, `accept` is low and `accept_id` is 0 while no request is present, `mask_q` is 7'h30 (EM and GM set) and `mode_q` is 0.
- R2: Fixed priority from highest to lowest, with identifiers: debug 1, unrecoverable 2, multiple-hit 3, bus error 4, non-maskable 5, exception 6, INT3 7, INT2 8, INT1 9, INT0 10. At most one event is accepted per cycle, and `accept_id` is 0 when none is accepted.
- R3: Mask layout: `mask_q` bits 0..3 mask INT0..INT3, bit 4 (EM) masks exceptions, bit 5 (GM) masks every interrupt level, and bit 6 (DM) masks debug. An interrupt level is accepted only when both its own bit and GM are clear. An exception is accepted only when EM is clear.
- R4: The four critical events are accepted whatever the mask bits hold.
- R5: A debug request is not accepted while DM is set. Accepting debug sets all seven mask bits and sets mode to 1.
- R6: Accepting an exception or a critical event sets EM, GM and all interrupt masks and leaves DM unchanged. Mode becomes 7 for the non-maskable interrupt and 6 for the other events in this group.
- R7: Accepting interrupt level n sets the masks of levels 0 to n and leaves the higher level masks, EM, GM and DM unchanged. Mode becomes 2+n.
- R8: `accept` and `accept_id` respond in the same cycle as the request. The status update takes effect at the next clock edge, so a request at the same or a lower priority that is still held in the next cycle is not accepted.
- R9: A request that is withdrawn while it is masked leaves no trace: unmasking it later produces no acceptance.
- R10: A write (`sr_wr`) loads `mask_q` and `mode_q` at the next edge when no event is accepted. In a cycle that accepts an event, the write is ignored and the acceptance update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_dbg | input | 1 | Debug request |
| req_unrec | input | 1 | Unrecoverable exception request |
| req_tlbmh | input | 1 | Translation multiple-hit request |
| req_buserr | input | 1 | Bus error request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_exc | input | 1 | Ordinary exception request |
| req_int | input | NUM_INT (4) | Interrupt level requests, bit n is level n |
| sr_wr | input | 1 | Load the status fields |
| sr_wr_mask | input | NUM_INT+3 (7) | Mask value to load |
| sr_wr_mode | input | 3 | Mode value to load |
| accept | output | 1 | An event is accepted in this cycle |
| accept_id | output | 4 | Identifier of the accepted event |
| mask_q | output | NUM_INT+3 (7) | Current mask bits |
| mode_q | output | 3 | Current mode |

## Verification
The bench targets the places where priority and masking interact:
- It raises a higher and a lower source together while the higher one is masked. A design that gates after arbitration would accept nothing, and one that ignores the mask would report the wrong identifier.
- It keeps a request held for one cycle after its acceptance. A design that raises no mask, or raises it a cycle late, would accept the same event twice.
- It checks that DM survives an exception entry, that the higher interrupt masks survive a lower-level entry, and that a write in an accepting cycle loses to the acceptance. A design that overwrote the whole field would corrupt the state it should keep.

// File: rtl/evtsel_pkg.sv
package evtsel_pkg;

  // Source positions, ordered by priority (0 is highest).
  localparam int SRC_DBG      = 0;
  localparam int SRC_UNREC    = 1;
  localparam int SRC_TLB      = 2;
  localparam int SRC_BUS      = 3;
  localparam int SRC_NMI      = 4;
  localparam int SRC_EXC      = 5;
  localparam int SRC_INT_BASE = 6;

  localparam int MODE_BASE  = 0;
  localparam int MODE_DEBUG = 1;

  function automatic int src_count(input int n_int);
    return SRC_INT_BASE + n_int;
  endfunction

  // Interrupt sources are placed from the top level down.
  function automatic int int_level(input int n_int, input int src);
    return n_int - 1 - (src - SRC_INT_BASE);
  endfunction

  function automatic int em_bit(input int n_int);
    return n_int;
  endfunction

  function automatic int gm_bit(input int n_int);
    return n_int + 1;
  endfunction

  function automatic int dm_bit(input int n_int);
    return n_int + 2;
  endfunction

  // Mode value after an event from position src is taken.
  function automatic int mode_after(input int n_int, input int src);
    if (src == SRC_DBG) return MODE_DEBUG;
    if (src == SRC_NMI) return n_int + 3;
    if (src <= SRC_EXC) return n_int + 2;
    return 2 + int_level(n_int, src);
  endfunction

endpackage

// File: rtl/evtsel_gate.sv
module evtsel_gate
  import evtsel_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NSRC    = SRC_INT_BASE + NUM_INT,
  parameter int MASK_W  = NUM_INT + 3
) (
  input  logic [NSRC-1:0]   raw,
  input  logic [MASK_W-1:0] mask_q,
  output logic [NSRC-1:0]   elig
);

  localparam int EM = em_bit(NUM_INT);
  localparam int GM = gm_bit(NUM_INT);
  localparam int DM = dm_bit(NUM_INT);

  assign elig[SRC_DBG] = raw[SRC_DBG] & ~mask_q[DM];

  for (genvar c = SRC_UNREC; c <= SRC_NMI; c++) begin : g_crit
    assign elig[c] = raw[c];
  end

  assign elig[SRC_EXC] = raw[SRC_EXC] & ~mask_q[EM];

  for (genvar g = 0; g < NUM_INT; g++) begin : g_int
    localparam int LVL = int_level(NUM_INT, SRC_INT_BASE + g);
    assign elig[SRC_INT_BASE+g] = raw[SRC_INT_BASE+g] & ~mask_q[LVL] & ~mask_q[GM];
  end

endmodule

// File: rtl/evtsel_pick.sv
module evtsel_pick #(
  parameter int NSRC = 10
) (
  input  logic [NSRC-1:0] elig,
  output logic [NSRC-1:0] grant,
  output logic            any
);

  logic [NSRC:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign grant[g]  = elig[g] & ~seen[g];
    assign seen[g+1] = seen[g] | elig[g];
  end

  assign any = seen[NSRC];

endmodule

// File: rtl/evtsel_status.sv
module evtsel_status
  import evtsel_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int IDX_W   = 4,
  parameter int MASK_W  = NUM_INT + 3,
  parameter int MODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [IDX_W-1:0]  take_idx,
  input  logic              wr,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [MASK_W-1:0] mask_q,
  output logic [MODE_W-1:0] mode_q
);

  localparam int EM = em_bit(NUM_INT);
  localparam int GM = gm_bit(NUM_INT);
  localparam int DM = dm_bit(NUM_INT);

  localparam logic [MASK_W-1:0] INT_ALL  = MASK_W'((1 << NUM_INT) - 1);
  localparam logic [MASK_W-1:0] EM_ONE   = MASK_W'(1 << EM);
  localparam logic [MASK_W-1:0] GM_ONE   = MASK_W'(1 << GM);
  localparam logic [MASK_W-1:0] DM_ONE   = MASK_W'(1 << DM);
  localparam logic [MASK_W-1:0] RST_MASK = EM_ONE | GM_ONE;

  // Raises every mask at or below the taken source.
  function automatic logic [MASK_W-1:0] raise(input int src, input logic [MASK_W-1:0] old);
    if (src == SRC_DBG) return old | INT_ALL | EM_ONE | GM_ONE | DM_ONE;
    if (src <= SRC_EXC) return old | INT_ALL | EM_ONE | GM_ONE;
    return old | MASK_W'((2 << int_level(NUM_INT, src)) - 1);
  endfunction

  logic [MASK_W-1:0] mask_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mask_d = mask_q;
    mode_d = mode_q;
    if (take) begin
      mask_d = raise(int'(take_idx), mask_q);
      mode_d = MODE_W'(mode_after(NUM_INT, int'(take_idx)));
    end else if (wr) begin
      mask_d = wr_mask;
      mode_d = wr_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_MASK;
      mode_q <= MODE_W'(MODE_BASE);
    end else begin
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/evtsel_unit.sv
module evtsel_unit
  import evtsel_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NSRC    = SRC_INT_BASE + NUM_INT,
  parameter int MASK_W  = NUM_INT + 3,
  parameter int MODE_W  = $clog2(NUM_INT + 4),
  parameter int ID_W    = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_dbg,
  input  logic               req_unrec,
  input  logic               req_tlbmh,
  input  logic               req_buserr,
  input  logic               req_nmi,
  input  logic               req_exc,
  input  logic [NUM_INT-1:0] req_int,
  input  logic               sr_wr,
  input  logic [MASK_W-1:0]  sr_wr_mask,
  input  logic [MODE_W-1:0]  sr_wr_mode,
  output logic               accept,
  output logic [ID_W-1:0]    accept_id,
  output logic [MASK_W-1:0]  mask_q,
  output logic [MODE_W-1:0]  mode_q
);

  // Named internal events, also observed by the checker.
  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;
  logic            any_elig;
  logic [ID_W-1:0] sel_idx;

  assign raw[SRC_DBG]   = req_dbg;
  assign raw[SRC_UNREC] = req_unrec;
  assign raw[SRC_TLB]   = req_tlbmh;
  assign raw[SRC_BUS]   = req_buserr;
  assign raw[SRC_NMI]   = req_nmi;
  assign raw[SRC_EXC]   = req_exc;

  for (genvar g = 0; g < NUM_INT; g++) begin : g_raw_int
    assign raw[SRC_INT_BASE+g] = req_int[NUM_INT-1-g];
  end

  evtsel_gate #(
    .NUM_INT(NUM_INT),
    .NSRC   (NSRC),
    .MASK_W (MASK_W)
  ) u_gate (
    .raw   (raw),
    .mask_q(mask_q),
    .elig  (elig)
  );

  evtsel_pick #(
    .NSRC(NSRC)
  ) u_pick (
    .elig (elig),
    .grant(grant),
    .any  (any_elig)
  );

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel_idx = ID_W'(i);
    end
  end

  assign accept    = any_elig;
  assign accept_id = any_elig ? sel_idx + 1'b1 : '0;

  evtsel_status #(
    .NUM_INT(NUM_INT),
    .IDX_W  (ID_W),
    .MASK_W (MASK_W),
    .MODE_W (MODE_W)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (any_elig),
    .take_idx(sel_idx),
    .wr      (sr_wr),
    .wr_mask (sr_wr_mask),
    .wr_mode (sr_wr_mode),
    .mask_q  (mask_q),
    .mode_q  (mode_q)
  );

endmodule

// File: rtl/evtsel_checks.sv
module evtsel_checks
  import evtsel_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NSRC    = SRC_INT_BASE + NUM_INT,
  parameter int MASK_W  = NUM_INT + 3,
  parameter int MODE_W  = $clog2(NUM_INT + 4),
  parameter int ID_W    = $clog2(NSRC + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_crit,
  input logic               sr_wr,
  input logic [MASK_W-1:0]  sr_wr_mask,
  input logic [MODE_W-1:0]  sr_wr_mode,
  input logic               accept,
  input logic [ID_W-1:0]    accept_id,
  input logic [MASK_W-1:0]  mask_q,
  input logic [MODE_W-1:0]  mode_q,
  input logic [NSRC-1:0]    grant
);

  localparam int EM = em_bit(NUM_INT);
  localparam int GM = gm_bit(NUM_INT);
  localparam int DM = dm_bit(NUM_INT);

  localparam logic [ID_W-1:0] ID_DBG  = ID_W'(SRC_DBG + 1);
  localparam logic [ID_W-1:0] ID_NMI  = ID_W'(SRC_NMI + 1);
  localparam logic [ID_W-1:0] ID_EXC  = ID_W'(SRC_EXC + 1);
  localparam logic [ID_W-1:0] ID_INT0 = ID_W'(NSRC);

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_id_tracks_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept == (accept_id != '0));

  a_r3_exc_needs_em_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id == ID_EXC) |-> !mask_q[EM]);

  a_r3_int_needs_gm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id > ID_EXC) |-> !mask_q[GM]);

  a_r4_critical_taken: assert property (@(posedge clk) disable iff (!rst_n)
    req_crit |-> (accept && accept_id <= ID_NMI));

  a_r5_dm_blocks_debug: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[DM] |-> !(accept && accept_id == ID_DBG));

  a_r5_debug_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id == ID_DBG) |=> (&mask_q));

  a_r6_exc_group_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id > ID_DBG && accept_id <= ID_EXC)
      |=> ((&mask_q[GM:0]) && mask_q[DM] == $past(mask_q[DM])));

  a_r7_int0_sets_own: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id == ID_INT0) |=> (mask_q[0] && mode_q == MODE_W'(2)));

  a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (accept_id == ID_DBG || accept_id >= ID_EXC))
      |=> !(accept && accept_id == $past(accept_id)));

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && sr_wr) |=> (mask_q == $past(sr_wr_mask) && mode_q == $past(sr_wr_mode)));

endmodule

bind evtsel_unit evtsel_checks #(
  .NUM_INT(NUM_INT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_crit  (req_unrec | req_tlbmh | req_buserr | req_nmi),
  .sr_wr     (sr_wr),
  .sr_wr_mask(sr_wr_mask),
  .sr_wr_mode(sr_wr_mode),
  .accept    (accept),
  .accept_id (accept_id),
  .mask_q    (mask_q),
  .mode_q    (mode_q),
  .grant     (grant)
);

// File: tb/evtsel_unit_test.sv
module evtsel_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_dbg = 1'b0, req_unrec = 1'b0, req_tlbmh = 1'b0;
  logic       req_buserr = 1'b0, req_nmi = 1'b0, req_exc = 1'b0;
  logic [3:0] req_int = '0;
  logic       sr_wr = 1'b0;
  logic [6:0] sr_wr_mask = '0;
  logic [2:0] sr_wr_mode = '0;
  logic       accept;
  logic [3:0] accept_id;
  logic [6:0] mask_q;
  logic [2:0] mode_q;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  evtsel_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_dbg(req_dbg), .req_unrec(req_unrec), .req_tlbmh(req_tlbmh),
    .req_buserr(req_buserr), .req_nmi(req_nmi), .req_exc(req_exc),
    .req_int(req_int), .sr_wr(sr_wr), .sr_wr_mask(sr_wr_mask),
    .sr_wr_mode(sr_wr_mode), .accept(accept), .accept_id(accept_id),
    .mask_q(mask_q), .mode_q(mode_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    req_dbg = 0; req_unrec = 0; req_tlbmh = 0; req_buserr = 0;
    req_nmi = 0; req_exc = 0; req_int = '0;
  endtask

  task automatic take(input string tag, input int id);
    #1;
    chk({tag, " accept"}, int'(accept), id != 0 ? 1 : 0);
    chk({tag, " id"}, int'(accept_id), id);
  endtask

  task automatic status(input string tag, input int m, input int md);
    chk({tag, " mask"}, int'(mask_q), m);
    chk({tag, " mode"}, int'(mode_q), md);
  endtask

  // Loads the status fields; returns at a falling edge with the load visible.
  task automatic load(input logic [6:0] m, input logic [2:0] md);
    @(negedge clk);
    sr_wr = 1; sr_wr_mask = m; sr_wr_mode = md;
    @(negedge clk);
    sr_wr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    take("R1 idle", 0);
    status("R1 reset", 'h30, 0);
  endtask

  task automatic t_int_levels();
    req_int = 4'hF;
    take("R3 GM blocks ints", 0);
    clear_reqs();
    load(7'h00, 3'd0);
    req_int = 4'b0010;
    take("R7 INT1", 9);
    @(negedge clk); #1;
    status("R7 after INT1", 'h03, 3);
    chk("R8 INT1 held blocked", int'(accept), 0);
    req_int = 4'b0110;
    take("R7 INT2 over INT1", 8);
    @(negedge clk);
    clear_reqs(); #1;
    status("R7 after INT2", 'h07, 4);
  endtask

  task automatic t_exc();
    load(7'h20, 3'd0);
    req_int = 4'b0001;
    take("R3 GM blocks INT0", 0);
    req_exc = 1;
    take("R3 exc with EM clear", 6);
    @(negedge clk); #1;
    status("R6 after exc", 'h3F, 6);
    chk("R8 exc held blocked", int'(accept), 0);
    clear_reqs();
    load(7'h10, 3'd0);
    req_exc = 1; req_int = 4'b0001;
    take("R3 EM blocks exc, INT0 taken", 10);
    @(negedge clk);
    clear_reqs();
  endtask

  task automatic t_critical();
    load(7'h7F, 3'd2);
    req_nmi = 1;
    take("R4 NMI all masked", 5);
    @(negedge clk);
    clear_reqs(); #1;
    status("R6 after NMI", 'h7F, 7);
    load(7'h00, 3'd0);
    req_buserr = 1;
    take("R4 bus error", 4);
    @(negedge clk);
    clear_reqs(); #1;
    status("R6 DM kept", 'h3F, 6);
    load(7'h7F, 3'd0);
    req_unrec = 1; req_tlbmh = 1; req_buserr = 1; req_nmi = 1;
    take("R2 unrec first", 2);
    @(negedge clk); req_unrec = 0;
    take("R2 tlb next", 3);
    @(negedge clk); req_tlbmh = 0;
    take("R2 bus next", 4);
    @(negedge clk); req_buserr = 0;
    take("R2 nmi last", 5);
    @(negedge clk);
    clear_reqs();
  endtask

  task automatic t_priority();
    load(7'h00, 3'd0);
    req_dbg = 1; req_unrec = 1; req_tlbmh = 1; req_buserr = 1;
    req_nmi = 1; req_exc = 1; req_int = 4'hF;
    take("R2 debug top", 1);
    @(negedge clk); #1;
    status("R5 after debug", 'h7F, 1);
    take("R5 debug held, unrec next", 2);
    clear_reqs();
    load(7'h00, 3'd0);
    req_exc = 1; req_int = 4'hF;
    take("R2 exc over ints", 6);
    clear_reqs();
    load(7'h00, 3'd0);
    req_int = 4'b1001;
    take("R2 INT3 over INT0", 7);
    @(negedge clk);
    clear_reqs(); #1;
    status("R7 after INT3", 'h0F, 5);
  endtask

  task automatic t_dm();
    load(7'h40, 3'd0);
    req_dbg = 1; req_int = 4'b0001;
    take("R5 DM blocks debug", 10);
    @(negedge clk);
    clear_reqs();
  endtask

  task automatic t_nolatch();
    load(7'h30, 3'd0);
    req_int = 4'b0001;
    take("R9 masked pulse", 0);
    @(negedge clk);
    clear_reqs();
    load(7'h00, 3'd0);
    take("R9 nothing after unmask", 0);
    @(negedge clk);
    take("R9 still nothing", 0);
    status("R9 mask untouched", 'h00, 0);
  endtask

  task automatic t_write();
    load(7'h2A, 3'd5);
    #1;
    status("R10 load", 'h2A, 5);
    load(7'h00, 3'd0);
    req_int = 4'b0100;
    sr_wr = 1; sr_wr_mask = 7'h00; sr_wr_mode = 3'd0;
    take("R10 accept during write", 8);
    @(negedge clk);
    sr_wr = 0;
    clear_reqs(); #1;
    status("R10 write ignored", 'h07, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_int_levels();
    t_exc();
    t_critical();
    t_priority();
    t_dm();
    t_nolatch();
    t_write();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule